// File: doc/BRIEF.md
# Fused Pre-Add / Multiply / Post-Op Arithmetic Element

This block is a programmable 16-bit arithmetic element meant to be tiled in a coarse-grained compute overlay. Each sample carries four operands, named A, D, B and C. The element can combine A and D in a pre-adder. It then multiplies that value by B, which comes either from its own input or from a stored immediate. A final stage merges the product with C using an add, a subtract, a pass-through or a bitwise function. A single element can therefore carry out up to three operations per sample. This lets a multiply node and a following add or subtract node collapse into one element.

The element is fully pipelined. It takes a new operand set on every clock and returns each result exactly three cycles later, together with a matching valid flag. The operation is chosen by a static configuration word. That word is written through a load strobe while no operands are in flight. Routing operands to the element, balancing path delays and delivering the configuration are left to the surrounding fabric.

Top module: `fme_top`

## Requirements
- R1: Synchronous active-high reset clears `out_valid` and `result` to 0. It also sets the configuration to all zeros, which means pre-mode A, routed B and function add, so that a post-reset sample yields C + A*B.
- R2: `out_valid` equals `in_valid` delayed by exactly three clock edges. The result of a sample appears on the same edge as its valid flag.
- R3: A new operand set is accepted on every cycle. Back-to-back samples produce back-to-back results in issue order.
- R4: The pre-adder mode field, at configuration bits [18:17], selects the multiplier's first factor: 0 gives A, 1 gives A+D, 2 gives A−D and 3 gives D. All arithmetic is modulo 2^16.
- R5: Configuration bit 16 selects the second factor. When it is 0 the factor is the routed B input. When it is 1 the factor is the immediate held in configuration bits [15:0], and B is ignored.
- R6: The product keeps only its low 16 bits. Overflow wraps silently.
- R7: The function field, at configuration bits [21:19], selects the arithmetic post-operations: 0 gives C + P, 1 gives C − P and 2 gives P, with wrap modulo 2^16.
- R8: The same function field selects the bitwise post-operations: 3 gives C AND P, 4 gives C OR P and 5 gives C XOR P. Codes 6 and 7 give 0.
- R9: While `out_valid` is low, `result` holds its last value. Operand inputs presented with `in_valid` low do not change it.
- R10: The configuration is captured on a clock edge where `cfg_we` is high. While `cfg_we` is low, changes on `cfg_word` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_word | input | 22 | Configuration: function [21:19], pre-mode [18:17], B source [16], immediate [15:0] |
| in_valid | input | 1 | Operand set present |
| a | input | 16 | Operand A (pre-adder) |
| d | input | 16 | Operand D (pre-adder) |
| b | input | 16 | Operand B (multiplier, routed) |
| c | input | 16 | Operand C (post-stage) |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Result |

## Verification
Some properties are checked on every cycle once the pipeline has filled after reset. These are the three-cycle valid latency, the holding of the result while no valid sample emerges, and the agreement of each emerging result with the operands seen three edges earlier under the current configuration, for both the arithmetic and the bitwise functions. Other behaviours only the directed scenarios can show. These are the reset values, the ordering of a dense stream, the wrap corner values, and that a configuration word presented without the strobe leaves behaviour unchanged.

// File: rtl/fme_pkg.sv
package fme_pkg;

    parameter int DW = 16;
    localparam int LATENCY = 3;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        PRE_A    = 2'd0,
        PRE_SUM  = 2'd1,
        PRE_DIFF = 2'd2,
        PRE_D    = 2'd3
    } pre_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_PASS = 3'd2,
        FN_AND  = 3'd3,
        FN_OR   = 3'd4,
        FN_XOR  = 3'd5,
        FN_RSV6 = 3'd6,
        FN_RSV7 = 3'd7
    } fn_e;

    typedef struct packed {
        fn_e   fn;
        pre_e  pre;
        logic  b_imm;
        word_t imm;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic  valid;
        word_t a;
        word_t d;
        word_t b;
        word_t c;
    } stg1_t;

    typedef struct packed {
        logic  valid;
        word_t prod;
        word_t z;
    } stg2_t;

    function automatic word_t pre_combine(pre_e m, word_t x, word_t y);
        word_t r;
        unique case (m)
            PRE_A:    r = x;
            PRE_SUM:  r = x + y;
            PRE_DIFF: r = x - y;
            default:  r = y;
        endcase
        return r;
    endfunction

    // Flat golden expression for checking, written without the stage split.
    function automatic word_t fme_eval(cfg_t k, word_t x, word_t y, word_t f, word_t z);
        word_t first;
        word_t p;
        first = (k.pre == PRE_D) ? y :
                (k.pre == PRE_A) ? x :
                (k.pre == PRE_SUM) ? word_t'(x + y) : word_t'(x - y);
        p = word_t'(first * (k.b_imm ? k.imm : f));
        if (k.fn == FN_ADD)  return word_t'(z + p);
        if (k.fn == FN_SUB)  return word_t'(z - p);
        if (k.fn == FN_PASS) return p;
        if (k.fn == FN_AND)  return z & p;
        if (k.fn == FN_OR)   return z | p;
        if (k.fn == FN_XOR)  return z ^ p;
        return '0;
    endfunction

endpackage

// File: rtl/fme_operand_reg.sv
module fme_operand_reg
    import fme_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  b_imm,
    input  word_t imm,
    input  logic  in_valid,
    input  word_t a,
    input  word_t d,
    input  word_t b,
    input  word_t c,
    output stg1_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            q.a     <= a;
            q.d     <= d;
            q.b     <= b_imm ? imm : b;
            q.c     <= c;
        end
    end
endmodule

// File: rtl/fme_mul_reg.sv
module fme_mul_reg
    import fme_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pre_e  pre,
    input  stg1_t s,
    output stg2_t q
);
    word_t factor;
    word_t prod_lo;

    always_comb begin
        factor  = pre_combine(pre, s.a, s.d);
        prod_lo = factor * s.b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= s.valid;
            q.prod  <= prod_lo;
            q.z     <= s.c;
        end
    end
endmodule

// File: rtl/fme_post_reg.sv
module fme_post_reg
    import fme_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fn_e   fn,
    input  stg2_t s,
    output logic  out_valid,
    output word_t result
);
    word_t alu;

    always_comb begin
        unique case (fn)
            FN_ADD:  alu = s.z + s.prod;
            FN_SUB:  alu = s.z - s.prod;
            FN_PASS: alu = s.prod;
            FN_AND:  alu = s.z & s.prod;
            FN_OR:   alu = s.z | s.prod;
            FN_XOR:  alu = s.z ^ s.prod;
            default: alu = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s.valid;
            if (s.valid) result <= alu;
        end
    end
endmodule

// File: rtl/fme_top.sv
module fme_top
    import fme_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             in_valid,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    d,
    input  logic [DW-1:0]    b,
    input  logic [DW-1:0]    c,
    output logic             out_valid,
    output logic [DW-1:0]    result
);
    cfg_t  cfg_q;
    stg1_t s1;
    stg2_t s2;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_t'(cfg_word);
    end

    fme_operand_reg u_opnd (
        .clk(clk), .rst(rst), .b_imm(cfg_q.b_imm), .imm(cfg_q.imm),
        .in_valid(in_valid), .a(a), .d(d), .b(b), .c(c), .q(s1)
    );

    fme_mul_reg u_mul (
        .clk(clk), .rst(rst), .pre(cfg_q.pre), .s(s1), .q(s2)
    );

    fme_post_reg u_post (
        .clk(clk), .rst(rst), .fn(cfg_q.fn), .s(s2),
        .out_valid(out_valid), .result(result)
    );
endmodule

// File: rtl/fme_checker.sv
module fme_checker
    import fme_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input word_t a,
    input word_t d,
    input word_t b,
    input word_t c,
    input cfg_t  cfg,
    input logic  out_valid,
    input word_t result
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)               warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (warm != 2'd0 && !out_valid) |-> $stable(result)); // R9

    AST_ARITH_MATCH: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && cfg.fn inside {FN_ADD, FN_SUB, FN_PASS}) |->
        (result == fme_eval(cfg, $past(a, 3), $past(d, 3), $past(b, 3), $past(c, 3)))); // R7

    AST_LOGIC_MATCH: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && out_valid && !(cfg.fn inside {FN_ADD, FN_SUB, FN_PASS})) |->
        (result == fme_eval(cfg, $past(a, 3), $past(d, 3), $past(b, 3), $past(c, 3)))); // R8
endmodule

bind fme_top fme_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .d(d), .b(b), .c(c),
    .cfg(cfg_q), .out_valid(out_valid), .result(result)
);

// File: tb/fme_top_bench.sv
module fme_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [21:0] cfg_word;
    logic        in_valid;
    logic [15:0] a, d, b, c;
    logic        out_valid;
    logic [15:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fme_top u_fme_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .in_valid(in_valid), .a(a), .d(d), .b(b), .c(c),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [21:0] mk(input int fn, input int pre, input logic bi, input logic [15:0] im);
        return {fn[2:0], pre[1:0], bi, im};
    endfunction

    function automatic logic [15:0] ref_eval(input logic [21:0] w, input logic [15:0] xa,
                                             input logic [15:0] xd, input logic [15:0] xb,
                                             input logic [15:0] xc);
        logic [15:0] m, f, p;
        case (w[18:17])
            2'd0: m = xa;
            2'd1: m = xa + xd;
            2'd2: m = xa - xd;
            default: m = xd;
        endcase
        f = w[16] ? w[15:0] : xb;
        p = m * f;
        case (w[21:19])
            3'd0: return xc + p;
            3'd1: return xc - p;
            3'd2: return p;
            3'd3: return xc & p;
            3'd4: return xc | p;
            3'd5: return xc ^ p;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [21:0] w);
        @(negedge clk);
        cfg_word = w; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one sample, sample output three edges later
    task automatic do_op(input string req, input logic [21:0] w, input logic [15:0] xa,
                         input logic [15:0] xd, input logic [15:0] xb, input logic [15:0] xc);
        @(negedge clk);
        a = xa; d = xd; b = xb; c = xc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req, {15'd0, out_valid}, 16'd1);
        chk(req, result, ref_eval(w, xa, xd, xb, xc));
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_we = 1'b0; cfg_word = '0; in_valid = 1'b0;
        a = 16'h1111; d = 16'h2222; b = 16'h3333; c = 16'h4444;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {15'd0, out_valid}, 16'd0);
        chk("R1 result in reset", result, 16'd0);
        rst = 1'b0;
        do_op("R1 default config", 22'd0, 16'd3, 16'd9, 16'd5, 16'd7);
        chk("R1 default value", result, 16'd22);
    endtask

    task automatic t_pre_modes();
        for (int m = 0; m < 4; m++) begin
            logic [21:0] w = mk(0, m, 1'b0, 16'h0);
            load_cfg(w);
            do_op($sformatf("R4 pre mode %0d", m), w, 16'd20, 16'd6, 16'd3, 16'd100);
        end
    endtask

    task automatic t_bsrc();
        logic [21:0] w = mk(2, 0, 1'b1, 16'd11);
        load_cfg(w);
        do_op("R5 immediate B", w, 16'd7, 16'd0, 16'hBEEF, 16'd0);
        chk("R5 immediate product", result, 16'd77);
        w = mk(2, 0, 1'b0, 16'd11);
        load_cfg(w);
        do_op("R5 routed B", w, 16'd7, 16'd0, 16'd4, 16'd0);
    endtask

    task automatic t_alu();
        for (int f = 0; f < 8; f++) begin
            logic [21:0] w = mk(f, 1, 1'b0, 16'h0);
            load_cfg(w);
            if (f < 3) do_op($sformatf("R7 fn %0d", f), w, 16'h0013, 16'h0002, 16'h0021, 16'hA5C3);
            else       do_op($sformatf("R8 fn %0d", f), w, 16'h0013, 16'h0002, 16'h0021, 16'hA5C3);
        end
    endtask

    task automatic t_wrap();
        logic [21:0] w = mk(2, 0, 1'b0, 16'h0);
        load_cfg(w);
        do_op("R6 product wrap", w, 16'h1234, 16'h0, 16'h0100, 16'h0);
        chk("R6 low bits", result, 16'h3400);
        w = mk(1, 0, 1'b0, 16'h0);
        load_cfg(w);
        do_op("R7 subtract wrap", w, 16'd3, 16'h0, 16'd4, 16'd5);
        chk("R7 negative wrap", result, 16'hFFF9);
        w = mk(0, 1, 1'b0, 16'h0);
        load_cfg(w);
        do_op("R4 pre-add wrap", w, 16'hFFFF, 16'h0002, 16'd3, 16'hFFFE);
        chk("R4 pre-add wrap value", result, 16'h0001);
    endtask

    task automatic t_stream();
        logic [21:0] w = mk(0, 2, 1'b0, 16'h0);
        logic [15:0] exp_q [5];
        load_cfg(w);
        for (int k = 0; k < 5; k++)
            exp_q[k] = ref_eval(w, 16'(50 + k * 7), 16'(k), 16'(k + 2), 16'(k * 1000));
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i == 2) chk("R2 no early valid", {15'd0, out_valid}, 16'd0);
            if (i >= 3 && i < 8) begin
                chk("R3 stream valid", {15'd0, out_valid}, 16'd1);
                chk($sformatf("R3 stream item %0d", i - 3), result, exp_q[i - 3]);
            end
            if (i == 8) chk("R2 valid drops", {15'd0, out_valid}, 16'd0);
            if (i < 5) begin
                a = 16'(50 + i * 7); d = 16'(i); b = 16'(i + 2); c = 16'(i * 1000);
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_hold();
        logic [21:0] w = mk(0, 0, 1'b0, 16'h0);
        logic [15:0] kept;
        load_cfg(w);
        do_op("R9 setup", w, 16'd2, 16'd0, 16'd2, 16'd1);
        kept = result;
        @(negedge clk);
        a = 16'h7777; b = 16'h0101; c = 16'h5555; in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 valid low", {15'd0, out_valid}, 16'd0);
        chk("R9 result held", result, kept);
    endtask

    task automatic t_cfg_ignore();
        logic [21:0] w = mk(0, 0, 1'b0, 16'h0);
        load_cfg(w);
        @(negedge clk);
        cfg_word = mk(5, 3, 1'b1, 16'h00FF);
        repeat (2) @(negedge clk);
        do_op("R10 word ignored without strobe", w, 16'd6, 16'd9, 16'd7, 16'd1);
        chk("R10 old config value", result, 16'd43);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_pre_modes();
        t_bsrc();
        t_alu();
        t_wrap();
        t_stream();
        t_hold();
        t_cfg_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule